// File: doc/BRIEF.md
# Four-Lane Fixed-Point Byte Multiplier

This block multiplies two 32-bit words lane by lane, as four independent byte pairs. Each byte is a fixed-point fraction. An unsigned byte has 8 fractional bits, so 0x80 stands for one half. A signed byte has 7 fractional bits, so 0x40 stands for one half and 0x80 for minus one. Each of the two inputs has its own signedness control, and so does the output. The result is rounded, either down or to nearest, and then clipped to the range of the chosen output format.

The second operand is either a register word or a 6-bit immediate. The immediate is padded with two zero bits on the right and used in every lane. All four lanes are computed in parallel. A result is registered one cycle after its operands are presented with `in_valid`, and it is held until the next valid operation. The block has no flag output.

Top module: `fmul_quad`

## Requirements
- R1: While `rst_n` is low, and after reset until the first valid operation, `out_valid` is 0 and `out_data` is 0.
- R2: The clock edge that samples `in_valid`=1 loads `out_data` and sets `out_valid`=1. A cycle with `in_valid`=0 clears `out_valid` and leaves `out_data` unchanged, whatever the other inputs do.
- R3: Lane i uses bits [8i+7:8i] of each operand. With the sign control for an input at 1, that byte is read as two's complement and doubled, giving a value from -256 to 254. With the control at 0, the byte is read as an unsigned value from 0 to 255. The product of the two converted values has 16 fractional bits.
- R4: With `out_unsigned`=1, the product has 0x80 added to it if `round_near`=1. It is then shifted right by 8, flooring toward minus infinity, and clipped to 0..255.
- R5: With `out_unsigned`=0, the product has 0x100 added to it if `round_near`=1. It is then shifted right by 9, flooring toward minus infinity, clipped to -128..127, and written as a two's complement byte.
- R6: `round_near`=0 rounds toward minus infinity. `round_near`=1 rounds to nearest, and an exact half rounds up (for example, unsigned 0x03 times 0x80 gives 0x02).
- R7: With `use_imm`=1, `src2` is ignored and every lane uses the byte {`imm`, 2'b00} as its second operand.
- R8: The lanes are independent: changing one lane's operands changes no other lane's result byte.
- R9: A source-1 word of zero gives a result of zero, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src1 | input | 32 | Source-1 word, four byte lanes |
| src2 | input | 32 | Source-2 word, used when `use_imm`=0 |
| imm | input | 6 | Immediate; lane byte is {imm,2'b00} |
| use_imm | input | 1 | 1 selects the immediate as source 2 |
| sign1 | input | 1 | 1 treats source-1 bytes as signed |
| sign2 | input | 1 | 1 treats source-2 bytes as signed |
| out_unsigned | input | 1 | 1 selects unsigned output, 0 selects signed output |
| round_near | input | 1 | 1 rounds to nearest with ties up, 0 rounds down |
| out_valid | output | 1 | `out_data` was loaded on the last edge |
| out_data | output | 32 | Four result bytes |

## Verification
The bench goes after six corner cases:
- Minus one times minus one in signed form. This must clip to 0x7F. A design that forgets the clip wraps it to 0x80.
- A negative product into an unsigned output. This must give 0. A design that shifts logically or skips the low clip gives a large byte instead.
- Exact half ties under round-to-nearest. A design that adds the wrong bias, or rounds ties away from zero, lands one step off.
- Small negative signed products under round-down. These must floor to 0xFF. A logical shift would give 0x00 or garbage.
- The immediate form, run with two different `src2` words. This exposes a source mux that leaks the register, or an immediate padded on the wrong side.
- Result holding while `in_valid` is low.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  // Per-operation arithmetic mode, shared by the top and the lanes.
  typedef struct packed {
    logic sign_a;    // source-1 bytes are signed
    logic sign_b;    // source-2 bytes are signed
    logic out_u;     // result is unsigned
    logic rnd_near;  // round to nearest, ties up
  } fmul_mode_t;
endpackage

// File: rtl/fmul_opsel.sv
module fmul_opsel #(
  parameter int LANES = 4,
  parameter int W     = 8,
  parameter int IMM_W = 6
) (
  input  logic [LANES*W-1:0] reg_word,
  input  logic [IMM_W-1:0]   imm,
  input  logic               use_imm,
  output logic [LANES*W-1:0] opnd
);
  localparam int PAD = W - IMM_W;

  // Immediate byte: value left-aligned, zero bits fill the low end.
  logic [W-1:0] imm_byte;
  assign imm_byte = {imm, {PAD{1'b0}}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign opnd[g*W +: W] = use_imm ? imm_byte : reg_word[g*W +: W];
  end
endmodule

// File: rtl/fmul_lane.sv
module fmul_lane
  import fmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fmul_mode_t   mode,
  output logic [W-1:0] y,
  output logic         sat_hi,
  output logic         sat_lo
);
  localparam int CW = W + 2;      // converted operand width
  localparam int PW = 2 * CW;     // product width
  localparam logic signed [PW-1:0] UMAX = PW'((1 << W) - 1);
  localparam logic signed [PW-1:0] SMAX = PW'((1 << (W - 1)) - 1);
  localparam logic signed [PW-1:0] SMIN = ~SMAX;

  // Bring a byte to W fractional bits.
  function automatic logic signed [CW-1:0] to_frac(input logic [W-1:0] v, input logic s);
    logic signed [CW-1:0] r;
    if (s) r = {v[W-1], v, 1'b0};
    else   r = {2'b00, v};
    return r;
  endfunction

  // Rounding bias for the selected output format.
  function automatic logic signed [PW-1:0] bias_of(input logic out_u, input logic rn);
    logic signed [PW-1:0] r;
    r = '0;
    if (rn) begin
      if (out_u) r[W-1] = 1'b1;
      else       r[W]   = 1'b1;
    end
    return r;
  endfunction

  // Saturate a scaled value to the output byte.
  function automatic logic [W-1:0] clip(input logic signed [PW-1:0] v, input logic out_u,
                                        input logic hi, input logic lo);
    logic [W-1:0] r;
    if (hi)      r = out_u ? UMAX[W-1:0] : SMAX[W-1:0];
    else if (lo) r = out_u ? '0 : SMIN[W-1:0];
    else         r = v[W-1:0];
    return r;
  endfunction

  logic signed [CW-1:0] fa, fb;
  logic signed [PW-1:0] prod, biased, scaled;

  assign fa     = to_frac(a, mode.sign_a);
  assign fb     = to_frac(b, mode.sign_b);
  assign prod   = PW'(fa) * PW'(fb);
  assign biased = prod + bias_of(mode.out_u, mode.rnd_near);
  assign scaled = mode.out_u ? (biased >>> W) : (biased >>> (W + 1));

  // Saturation events, brought out for the assertions in the top.
  assign sat_hi = mode.out_u ? (scaled > UMAX) : (scaled > SMAX);
  assign sat_lo = mode.out_u ? (scaled < 0)    : (scaled < SMIN);
  assign y      = clip(scaled, mode.out_u, sat_hi, sat_lo);
endmodule

// File: rtl/fmul_quad.sv
module fmul_quad
  import fmul_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 8,
  parameter int IMM_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [LANES*W-1:0] src1,
  input  logic [LANES*W-1:0] src2,
  input  logic [IMM_W-1:0]   imm,
  input  logic               use_imm,
  input  logic               sign1,
  input  logic               sign2,
  input  logic               out_unsigned,
  input  logic               round_near,
  output logic               out_valid,
  output logic [LANES*W-1:0] out_data
);
  localparam int DW = LANES * W;

  fmul_mode_t     mode;
  logic [DW-1:0]  opnd_b;
  logic [DW-1:0]  lane_y;
  logic [LANES-1:0] sat_hi, sat_lo;
  logic [LANES-1:0] sat_hi_q, sat_lo_q;
  logic             out_u_q;

  assign mode = '{sign_a: sign1, sign_b: sign2, out_u: out_unsigned, rnd_near: round_near};

  fmul_opsel #(.LANES(LANES), .W(W), .IMM_W(IMM_W)) opsel_i (
    .reg_word (src2),
    .imm      (imm),
    .use_imm  (use_imm),
    .opnd     (opnd_b)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fmul_lane #(.W(W)) lane_i (
      .a      (src1[g*W +: W]),
      .b      (opnd_b[g*W +: W]),
      .mode   (mode),
      .y      (lane_y[g*W +: W]),
      .sat_hi (sat_hi[g]),
      .sat_lo (sat_lo[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      sat_hi_q  <= '0;
      sat_lo_q  <= '0;
      out_u_q   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= lane_y;
        sat_hi_q <= sat_hi;
        sat_lo_q <= sat_lo;
        out_u_q  <= out_unsigned;
      end
    end
  end

  // R2: one-cycle latency; the result holds while idle
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R9: a zero source-1 word gives zero in every mode
  a_r9_zero_src1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src1 == '0) |=> (out_data == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R4: unsigned output saturates to all ones or to zero
    a_r4_clip_unsigned_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_u_q && sat_hi_q[g]) |-> (out_data[g*W +: W] == {W{1'b1}}));
    a_r4_clip_unsigned_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_u_q && sat_lo_q[g]) |-> (out_data[g*W +: W] == '0));
    // R5: signed output saturates to the largest positive or most negative byte
    a_r5_clip_signed_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_u_q && sat_hi_q[g]) |-> (out_data[g*W +: W] == {1'b0, {(W-1){1'b1}}}));
    a_r5_clip_signed_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_u_q && sat_lo_q[g]) |-> (out_data[g*W +: W] == {1'b1, {(W-1){1'b0}}}));
    // R4/R5: a lane cannot saturate both ways at once
    a_r5_sat_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(sat_hi_q[g] && sat_lo_q[g]));
  end
endmodule

// File: tb/fmul_quad_tb.sv
module fmul_quad_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src1 = '0, src2 = '0;
  logic [5:0]  imm = '0;
  logic        use_imm = 1'b0, sign1 = 1'b0, sign2 = 1'b0;
  logic        out_unsigned = 1'b0, round_near = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fmul_quad dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src1(src1), .src2(src2),
    .imm(imm), .use_imm(use_imm), .sign1(sign1), .sign2(sign2),
    .out_unsigned(out_unsigned), .round_near(round_near),
    .out_valid(out_valid), .out_data(out_data)
  );

  // ctrl = {use_imm, sign1, sign2, out_unsigned, round_near}
  // layout: ctrl[106:102] src1[101:70] src2[69:38] imm[37:32] expected[31:0]
  localparam int NV = 9;
  localparam logic [106:0] VEC [NV] = '{
    {5'b00010, 32'h80808080, 32'h80808080, 6'h00, 32'h40404040}, // R4 half*half
    {5'b00011, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'h00, 32'hFEFEFEFE}, // R4 R6 near max
    {5'b01100, 32'h007F8040, 32'h007F8040, 6'h00, 32'h007E7F20}, // R5 -1*-1 clips
    {5'b01100, 32'h0000FF80, 32'h00000140, 6'h00, 32'h0000FFC0}, // R5 R6 floor negative
    {5'b01101, 32'h0000FF80, 32'h00000140, 6'h00, 32'h000000C0}, // R6 nearest negative
    {5'b01010, 32'h00007F80, 32'h0000FFFF, 6'h00, 32'h0000FD00}, // R3 R4 negative clips to 0
    {5'b10010, 32'hFF804001, 32'h12345678, 6'h3F, 32'hFB7E3F00}, // R7 immediate
    {5'b00000, 32'h000080FF, 32'h000080FF, 6'h00, 32'h0000207F}, // R5 unsigned in, signed out
    {5'b00011, 32'h00000301, 32'h00008080, 6'h00, 32'h00000201}  // R6 ties round up
  };

  function automatic int conv(input logic [7:0] v, input bit s);
    return s ? 2 * int'($signed(v)) : int'(v);
  endfunction

  // Reference lane: floor division written out, then clipping.
  function automatic logic [7:0] ref_lane(input logic [7:0] a, input logic [7:0] b,
                                          input bit s1, input bit s2, input bit ou, input bit rn);
    int p, d, t, q;
    p = conv(a, s1) * conv(b, s2);
    d = ou ? 256 : 512;
    t = p + (rn ? d / 2 : 0);
    q = (t >= 0) ? t / d : -((-t + d - 1) / d);
    if (ou) begin
      if (q < 0) q = 0;
      if (q > 255) q = 255;
    end else begin
      if (q < -128) q = -128;
      if (q > 127) q = 127;
    end
    return q[7:0];
  endfunction

  function automatic logic [31:0] ref_word(input logic [4:0] c, input logic [31:0] a,
                                           input logic [31:0] b, input logic [5:0] im);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] bb;
      bb = c[4] ? {im, 2'b00} : b[8*i +: 8];
      r[8*i +: 8] = ref_lane(a[8*i +: 8], bb, c[3], c[2], c[1], c[0]);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Present one operation, then sample after the loading edge.
  task automatic apply(input logic [4:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [5:0] im);
    @(negedge clk);
    {use_imm, sign1, sign2, out_unsigned, round_near} = c;
    src1 = a; src2 = b; imm = im; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog R2 act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed, first, a, b;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 out_data in reset", out_data, 32'h0);
    check("R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_data after reset", out_data, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][106:102], VEC[i][101:70], VEC[i][69:38], VEC[i][37:32]);
      check("R2 out_valid after load", {31'b0, out_valid}, 32'h1);
      check("R3 R4 R5 R6 table vector", out_data, VEC[i][31:0]);
    end

    // R2: idle cycles hold data and clear valid
    first = out_data;
    src1 = 32'hDEADBEEF; src2 = 32'h01234567; out_unsigned = ~out_unsigned;
    repeat (2) @(negedge clk);
    check("R2 hold data", out_data, first);
    check("R2 valid low when idle", {31'b0, out_valid}, 32'h0);

    // R7: src2 ignored with immediate selected
    apply(5'b10011, 32'h80C0FF10, 32'hAAAAAAAA, 6'h25);
    first = out_data;
    check("R7 immediate vs model", out_data, ref_word(5'b10011, 32'h80C0FF10, 32'h0, 6'h25));
    apply(5'b10011, 32'h80C0FF10, 32'h55555555, 6'h25);
    check("R7 src2 ignored", out_data, first);

    // R8: lane independence
    apply(5'b01100, 32'h40404040, 32'h7F7F7F7F, 6'h00);
    first = out_data;
    apply(5'b01100, 32'h40404080, 32'h7F7F7F7F, 6'h00);
    check("R8 untouched lanes", {out_data[31:8], 8'h00}, {first[31:8], 8'h00});
    check("R8 changed lane", out_data, ref_word(5'b01100, 32'h40404080, 32'h7F7F7F7F, 6'h0));

    // R9: zero source 1 in every mode
    for (int c = 0; c < 32; c += 5) begin
      apply(5'(c), 32'h0, 32'hFF80017F, 6'h3F);
      check("R9 zero source", out_data, 32'h0);
    end

    // Sweep of all control combinations against the reference model
    seed = 32'h1F2E3D4C;
    for (int i = 0; i < 96; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223;
      b = seed;
      apply(5'(i), a, b, b[13:8]);
      check("R3 R4 R5 R6 R7 sweep", out_data, ref_word(5'(i), a, b, b[13:8]));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule